// File: doc/BRIEF.md
# Raster Beam Position Counter

This block tracks where the video beam is on the raster. A horizontal count advances on every clock, which is the pixel clock. When the horizontal count reaches the end of the line it returns to zero. The vertical count steps one clock later. Line length and frame length are parameters, and both counts wrap to zero.

Software reads the position through two 16-bit read-only registers on a word-wide bus. The upper register carries only the top vertical bit, bit 8. The lower register carries the low eight vertical bits in its high byte and the horizontal position in its low byte. The read path is combinational from the counters. A reader that fetches the two words at different cycles, or that reads at the very start of a line, can therefore see a torn position. The block shows that exactly and does not hide it.

Two one-cycle strobes mark the first cycle of each new line and the first cycle of each new frame.

Top module: `beam_pos_top`

## Requirements
- R1: While `rst_n` is low, both position registers read as zero and `line_start` and `frame_start` are low. The first cycle after release is horizontal 0, line 0.
- R2: On every clock the horizontal count increments by one. From `H_TOTAL-1` it returns to 0.
- R3: The line number changes one clock after the horizontal count returns to 0. In the cycle where the horizontal count is 0, the old line number is still read. For example, the upper word read in that cycle at the 255-to-256 boundary and the lower word read one cycle later together give line 0.
- R4: The line number wraps from `V_TOTAL-1` to 0. `frame_start` is high for exactly the first cycle in which the line number reads 0 after that wrap, and it is never high directly after reset.
- R5: `line_start` is high exactly in the cycles where the horizontal count is 0 after a wrap, and not in the first cycle after reset.
- R6: The upper register is at word address `UPPER_WADDR` (default 2). Bit 0 holds vertical bit 8, and bits 15:1 read zero.
- R7: The lower register is at word address `LOWER_WADDR` (default 3). Bits 15:8 hold vertical bits 7:0, and bits 7:0 hold the horizontal count, zero-extended.
- R8: The byte enables select the lanes: `bus_be[1]` selects bits 15:8 and `bus_be[0]` selects bits 7:0. A lane that is not selected reads zero.
- R9: `bus_rdata` is zero when `bus_rd` is low, when `bus_wr` is high, or when the address matches neither register.
- R10: A write to either register, at any cycle, changes neither count nor any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe; ignored by the counters |
| bus_be | input | 2 | Byte lane enables (bit 1 = high byte) |
| bus_rdata | output | 16 | Combinational read data |
| line_start | output | 1 | One-cycle pulse in the first cycle of a line |
| frame_start | output | 1 | One-cycle pulse in the first cycle of a frame |

## Verification
The assertions take three things for granted:
- The bus inputs settle between clock edges, since read data is a pure function of them and of the counters.
- Reset is held for at least one edge.
- The parameters keep the horizontal count within eight bits and the line number within nine.

The stimulus changes the address, strobes and byte enables only after the falling edge and samples before the next rising edge. It holds writes across rising edges at scattered cycles, so their lack of effect shows up in the following reads. It uses a short line and a 260-line frame, so that line 256 and two full frame wraps are reached.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int REG_W   = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = REG_W / LANE_W;
  localparam int VFULL_W = 9;
  localparam int HFLD_W  = 8;

  typedef logic [REG_W-1:0]   word_t;
  typedef logic [VFULL_W-1:0] vfull_t;
  typedef logic [HFLD_W-1:0]  hfld_t;

  function automatic word_t pack_upper(input vfull_t v);
    word_t w;
    w    = '0;
    w[0] = v[VFULL_W-1];
    return w;
  endfunction

  function automatic word_t pack_lower(input vfull_t v, input hfld_t h);
    return {v[HFLD_W-1:0], h};
  endfunction
endpackage

// File: rtl/beam_hcnt.sv
module beam_hcnt #(
  parameter int H_TOTAL = 227,
  parameter int H_W     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [H_W-1:0] hcnt,
  output logic           line_start
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);

  logic end_of_line;
  assign end_of_line = (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt       <= '0;
      line_start <= 1'b0;
    end else begin
      hcnt       <= end_of_line ? '0 : hcnt + 1'b1;
      line_start <= end_of_line;
    end
  end
endmodule

// File: rtl/beam_vcnt.sv
module beam_vcnt #(
  parameter int V_TOTAL = 312,
  parameter int V_W     = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  output logic [V_W-1:0] vcnt,
  output logic           frame_start
);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

  logic at_last;
  assign at_last = (vcnt == V_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt        <= '0;
      frame_start <= 1'b0;
    end else begin
      if (step) vcnt <= at_last ? '0 : vcnt + 1'b1;
      frame_start <= step && at_last;
    end
  end
endmodule

// File: rtl/beam_regfile.sv
module beam_regfile
  import beam_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int UPPER_WADDR = 2,
  parameter int LOWER_WADDR = 3,
  parameter int H_W         = 8,
  parameter int V_W         = 9
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [H_W-1:0]    hcnt,
  input  logic [V_W-1:0]    vcnt,
  output word_t             bus_rdata
);
  vfull_t v_ext;
  hfld_t  h_ext;
  word_t  sel_word;
  logic   rd_ok;

  assign v_ext = VFULL_W'(vcnt);
  assign h_ext = HFLD_W'(hcnt);
  assign rd_ok = bus_rd && !bus_wr;

  always_comb begin
    sel_word = '0;
    if (rd_ok) begin
      if (bus_addr == ADDR_W'(UPPER_WADDR))      sel_word = pack_upper(v_ext);
      else if (bus_addr == ADDR_W'(LOWER_WADDR)) sel_word = pack_lower(v_ext, h_ext);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_rdata[g*LANE_W +: LANE_W] = bus_be[g] ? sel_word[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/beam_pos_top.sv
module beam_pos_top
  import beam_pkg::*;
#(
  parameter int H_TOTAL     = 227,
  parameter int V_TOTAL     = 312,
  parameter int ADDR_W      = 7,
  parameter int UPPER_WADDR = 2,
  parameter int LOWER_WADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  output logic [15:0]       bus_rdata,
  output logic              line_start,
  output logic              frame_start
);
  localparam int H_W = $clog2(H_TOTAL);
  localparam int V_W = $clog2(V_TOTAL);

  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;

  beam_hcnt #(.H_TOTAL(H_TOTAL), .H_W(H_W)) u_h (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_start(line_start)
  );

  beam_vcnt #(.V_TOTAL(V_TOTAL), .V_W(V_W)) u_v (
    .clk(clk), .rst_n(rst_n), .step(line_start), .vcnt(vcnt), .frame_start(frame_start)
  );

  beam_regfile #(
    .ADDR_W(ADDR_W), .UPPER_WADDR(UPPER_WADDR), .LOWER_WADDR(LOWER_WADDR),
    .H_W(H_W), .V_W(V_W)
  ) u_regs (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
    .hcnt(hcnt), .vcnt(vcnt), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/beam_pos_chk.sv
module beam_pos_chk #(
  parameter int H_TOTAL     = 227,
  parameter int V_TOTAL     = 312,
  parameter int ADDR_W      = 7,
  parameter int UPPER_WADDR = 2,
  parameter int H_W         = 8,
  parameter int V_W         = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [1:0]        bus_be,
  input logic [15:0]       bus_rdata,
  input logic              line_start,
  input logic              frame_start,
  input logic [H_W-1:0]    hcnt,
  input logic [V_W-1:0]    vcnt
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

  logic [8:0] v9;
  assign v9 = 9'(vcnt);

  // R2
  h_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hcnt <= H_LAST);
  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt != H_LAST |=> hcnt == $past(hcnt) + 1'b1);
  // R5
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt == H_LAST |=> (hcnt == '0) && line_start);
  // R3
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(vcnt));
  // R3
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && vcnt != V_LAST |=> vcnt == $past(vcnt) + 1'b1);
  // R4
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && vcnt == V_LAST |=> (vcnt == '0) && frame_start);
  // R4
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd || bus_wr |-> bus_rdata == 16'h0000);
  // R6
  upper_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == ADDR_W'(UPPER_WADDR) && bus_be == 2'b11
    |-> bus_rdata == {15'b0, v9[8]});
endmodule

bind beam_pos_top beam_pos_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .ADDR_W(ADDR_W),
  .UPPER_WADDR(UPPER_WADDR), .H_W(H_W), .V_W(V_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_be(bus_be), .bus_rdata(bus_rdata), .line_start(line_start),
  .frame_start(frame_start), .hcnt(hcnt), .vcnt(vcnt)
);

// File: tb/tb_beam_pos_top.sv
module tb_beam_pos_top;
  localparam int H  = 5;
  localparam int V  = 260;
  localparam int AW = 4;
  localparam logic [AW-1:0] UP = 4'd2;
  localparam logic [AW-1:0] LO = 4'd3;
  localparam int NCYC = 2 * V * H + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_be = 2'b00;
  logic [15:0]   bus_rdata;
  logic          line_start, frame_start;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  beam_pos_top #(.H_TOTAL(H), .V_TOTAL(V), .ADDR_W(AW), .UPPER_WADDR(2), .LOWER_WADDR(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .line_start(line_start), .frame_start(frame_start)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [1:0] be, input logic r,
                        input logic w, output logic [15:0] q);
    bus_addr = a; bus_be = be; bus_rd = r; bus_wr = w;
    #1;
    q = bus_rdata;
  endtask

  task automatic run_main();
    logic [15:0] q;
    logic [15:0] torn_up;
    logic        wrote;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 strobes", {30'b0, line_start, frame_start}, 32'h0);
    access(UP, 2'b11, 1'b1, 1'b0, q); check("R1 upper", 32'(q), 32'h0);
    access(LO, 2'b11, 1'b1, 1'b0, q); check("R1 lower", 32'(q), 32'h0);
    @(negedge clk);
    rst_n   = 1'b1;
    wrote   = 1'b0;
    torn_up = '0;
    for (int k = 0; k < NCYC; k++) begin
      int eh, ev;
      logic els, efs;
      logic [15:0] elo;
      eh  = k % H;
      ev  = (k == 0) ? 0 : ((k - 1) / H) % V;
      els = (k > 0) && (eh == 0);
      efs = (k > 1) && (((k - 1) % (V * H)) == 0);
      elo = {8'(ev), 8'(eh)};
      // R5 line strobe, R4 frame strobe
      check("R5 line_start", 32'(line_start), 32'(els));
      check("R4 frame_start", 32'(frame_start), 32'(efs));
      // R6 upper word
      access(UP, 2'b11, 1'b1, 1'b0, q);
      check("R6 upper", 32'(q), 32'((ev >> 8) & 1));
      if (k == 256 * H) torn_up = q;
      // R7 lower word; R10 after a write held across the edge
      access(LO, 2'b11, 1'b1, 1'b0, q);
      check(wrote ? "R10 lower after write" : "R7 lower", 32'(q), 32'(elo));
      if (k == 256 * H) begin
        // R3: horizontal already 0, line still 255
        check("R3 old line at h=0", 32'(q), 32'h0000_FF00);
      end
      if (k == 256 * H + 1) begin
        // R3: torn two-word read gives line 0 instead of 256
        check("R3 torn read", {torn_up, q}, 32'h0000_0001);
        check("R3 settled upper", 32'(torn_up), 32'h0);
      end
      // R8 byte lanes
      if (k % 2 == 1) begin
        access(LO, 2'b10, 1'b1, 1'b0, q);
        check("R8 high lane", 32'(q), 32'({elo[15:8], 8'h00}));
      end else begin
        access(LO, 2'b01, 1'b1, 1'b0, q);
        check("R8 low lane", 32'(q), 32'({8'h00, elo[7:0]}));
      end
      // R9 gated reads
      if (k % 3 == 0) begin
        access(LO, 2'b11, 1'b1, 1'b1, q); check("R9 read with write", 32'(q), 32'h0);
      end else if (k % 3 == 1) begin
        access(4'd0, 2'b11, 1'b1, 1'b0, q); check("R9 unmatched addr", 32'(q), 32'h0);
      end else begin
        access(LO, 2'b11, 1'b0, 1'b0, q); check("R9 no read", 32'(q), 32'h0);
      end
      // R10: hold a write to a position register across the coming edge
      wrote = (k % 7 == 3);
      if (wrote) begin
        bus_addr = (k % 2 == 0) ? UP : LO; bus_be = 2'b11; bus_rd = 1'b0; bus_wr = 1'b1;
      end else begin
        bus_rd = 1'b0; bus_wr = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule